// File: doc/BRIEF.md
# Vectored Interrupt Arbiter

This block collects interrupt events from a set of peripheral sources and turns them into a single vector request for a processor core. Every source owns a pending flag that latches on its event. Source 0 is the reset source: it is always eligible and always wins. Every other source also needs its own enable bit and the shared global enable.

When at least one source is eligible, the arbiter grants the one with the lowest index. It raises a one-cycle take pulse and presents the registered vector address of that source. On the same clock edge it drops the global enable and clears the served flag. A return strobe from the core sets the global enable again, so sources that became pending meanwhile are then served in index order. Software may also set the global enable during service, which lets a pending source preempt the running handler.

A small register port gives software access to the enables, the flags and the global bit. Flags are cleared by writing 1. Priority comes only from the index; there is no priority register.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset, the take pulse is 0, the vector address is 0, and the enable, flag and control registers all read 0.
- R2: A source event latches that source's flag whether or not it is enabled and whatever the global enable is. An event wins over any clear (bus or take) of the same flag in the same cycle.
- R3: A bus write to the flag register (address 1) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R4: The register map is combinational on read with bus_sel_i high: address 0 holds the enables (bit i for source i; bit 0 always reads 0 and ignores writes), address 1 holds the flags, address 2 bit 0 holds the global enable, and address 3 reads 0.
- R5: A source with index 1 or above is taken only while its flag, its enable bit and the global enable are all 1.
- R6: Source 0 is taken whenever its flag is set, regardless of the enables and the global enable.
- R7: When several sources are eligible, the one with the lowest index is taken, and exactly one source is granted per take.
- R8: A take shows as vec_take_o high for one cycle, with vec_addr_o equal to the index shifted left by VEC_SHIFT. The address holds until the next take. On the same edge the global enable reads 0 and the served flag is cleared.
- R9: An event sampled at clock edge k produces the take pulse after edge k+1 when the source is already eligible.
- R10: The return strobe sets the global enable. Flags raised during service stay pending and are taken in index order after the return. For the global enable in one cycle, a take overrides a bus write, which overrides the strobe.
- R11: When software sets the global enable during service, an enabled pending source is taken at once (nested service).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_event_i | input | NUM_SRC | One bit per source; 1 sets that source's flag |
| reti_i | input | 1 | Return-from-service strobe; sets the global enable |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, 0 when not selected |
| vec_take_o | output | 1 | One-cycle pulse per vector take |
| vec_addr_o | output | IDX_W+VEC_SHIFT | Registered vector address of the last take |

## Verification
The bench builds the block with thirteen sources, a 16-bit bus and VEC_SHIFT set to 1. The 16-bit bus lets the bench check that the unused upper enable bits and bit 0 read back as 0. With VEC_SHIFT at 1 the vector addresses are twice the index, so a wrong shift shows up as a wrong address. The full source count reaches the highest index, 12, and spreads the pending sets used in the ordering tests far enough apart that a wrong pick gives a visibly different address. Same-cycle collisions are also driven: an event against a bus clear, and an event against the take of its own flag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Register addresses seen on the bus port
    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_FLAG   = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    // Position of the global enable inside the control register
    localparam int CTRL_GIE_BIT = 0;

endpackage

// File: rtl/irq_arb_flags.sv
module irq_arb_flags #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic [NUM_SRC-1:0] w1c_i,
    input  logic [NUM_SRC-1:0] take_clr_i,
    output logic [NUM_SRC-1:0] flag_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } flag_state_t;

    flag_state_t state_d, state_q;

    // Clears first, then a new event sets the bit again (set wins)
    always_comb begin
        state_d      = state_q;
        state_d.flag = (state_q.flag & ~w1c_i & ~take_clr_i) | event_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;

    // R2: every event is held in its flag after the edge that samples it
    p_event_latched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|event_i) |=> ((flag_o & $past(event_i)) == $past(event_i)));

    // R3: a bus clear without a colliding event empties the flag
    p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(w1c_i & ~event_i)) |=> ((flag_o & $past(w1c_i & ~event_i)) == '0));

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic               any_o,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o
);

    // below[i] is 1 when some lower index is eligible
    logic [NUM_SRC:0] below;

    assign below[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign grant_o[g]  = elig_i[g] & ~below[g];
        assign below[g+1]  = below[g] | elig_i[g];
    end

    assign any_o = below[NUM_SRC];

    // Encode the one-hot grant into an index
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int BUS_W   = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic               reti_i,
    input  logic               take_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               gie_o,
    output logic [NUM_SRC-1:0] w1c_o,
    output logic [BUS_W-1:0]   bus_rdata_o
);

    localparam logic [NUM_SRC-1:0] SRC0_MASK = {{(NUM_SRC-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               gie;
    } reg_state_t;

    reg_state_t state_d, state_q;
    reg_addr_e  addr;
    logic       wr;
    logic       unused_wdata;

    assign addr         = reg_addr_e'(bus_addr_i);
    assign wr           = bus_sel_i & bus_we_i;
    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        state_d = state_q;
        w1c_o   = '0;
        // lowest precedence: return strobe
        if (reti_i) begin
            state_d.gie = 1'b1;
        end
        if (wr) begin
            unique case (addr)
                ADDR_ENABLE: state_d.en  = bus_wdata_i[NUM_SRC-1:0] & ~SRC0_MASK;
                ADDR_FLAG:   w1c_o       = bus_wdata_i[NUM_SRC-1:0];
                ADDR_CTRL:   state_d.gie = bus_wdata_i[CTRL_GIE_BIT];
                default:     ;
            endcase
        end
        // highest precedence: a take closes the global enable
        if (take_i) begin
            state_d.gie = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (addr)
                ADDR_ENABLE: bus_rdata_o = BUS_W'(state_q.en);
                ADDR_FLAG:   bus_rdata_o = BUS_W'(flag_i);
                ADDR_CTRL:   bus_rdata_o = BUS_W'(state_q.gie) << CTRL_GIE_BIT;
                default:     bus_rdata_o = '0;
            endcase
        end
    end

    assign en_o  = state_q.en;
    assign gie_o = state_q.gie;

    // R10: a return strobe with no competing write or take opens the global enable
    p_reti_sets_gie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && !take_i && !(wr && addr == ADDR_CTRL)) |=> gie_o);

    // R4: bit 0 of the enable register never holds a 1
    p_en_bit0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr |=> !en_o[0]);

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
    parameter  int NUM_SRC   = 13,
    parameter  int BUS_W     = 16,
    parameter  int VEC_SHIFT = 0,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W    = IDX_W + VEC_SHIFT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_event_i,
    input  logic               reti_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    output logic               vec_take_o,
    output logic [ADDR_W-1:0]  vec_addr_o
);

    localparam logic [NUM_SRC-1:0] SRC0_MASK = {{(NUM_SRC-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             take;
        logic [IDX_W-1:0] idx;
    } out_state_t;

    logic [NUM_SRC-1:0] flag;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] w1c;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               any;
    logic               gie;
    out_state_t         out_d, out_q;

    irq_arb_flags #(
        .NUM_SRC (NUM_SRC)
    ) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .event_i    (src_event_i),
        .w1c_i      (w1c),
        .take_clr_i (grant),
        .flag_o     (flag)
    );

    irq_arb_regs #(
        .NUM_SRC (NUM_SRC),
        .BUS_W   (BUS_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flag_i      (flag),
        .reti_i      (reti_i),
        .take_i      (any),
        .en_o        (en),
        .gie_o       (gie),
        .w1c_o       (w1c),
        .bus_rdata_o (bus_rdata_o)
    );

    // Source 0 bypasses both enables; the rest need their bit and the global bit
    assign elig = flag & (en | SRC0_MASK) & ({NUM_SRC{gie}} | SRC0_MASK);

    irq_arb_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .elig_i  (elig),
        .any_o   (any),
        .grant_o (grant),
        .idx_o   (win_idx)
    );

    always_comb begin
        out_d      = out_q;
        out_d.take = any;
        if (any) begin
            out_d.idx = win_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign vec_take_o = out_q.take;
    assign vec_addr_o = ADDR_W'(out_q.idx) << VEC_SHIFT;

    // R5: with the global enable closed and no reset request, nothing is taken
    p_masked_no_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gie && !flag[0]) |=> !vec_take_o);

    // R6: a pending reset source is taken on the next edge at index 0
    p_reset_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag[0] |=> (vec_take_o && out_q.idx == '0));

    // R7: at most one source is granted in a cycle
    p_single_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    // R7: the taken source had its flag pending
    p_taken_was_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_take_o |-> (|($past(flag) & (SRC0_MASK << out_q.idx))));

    // R8: a take leaves the global enable closed
    p_take_closes_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_take_o |-> !gie);

    // R8: the served flag survives only through a colliding event
    p_served_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_take_o |-> ((flag & (SRC0_MASK << out_q.idx))
                        == ($past(src_event_i) & (SRC0_MASK << out_q.idx))));

    // R8: the vector address holds between takes
    p_addr_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_take_o |-> $stable(vec_addr_o));

endmodule

// File: tb/irq_vec_arbiter_bench.sv
`timescale 1ns/1ps
module irq_vec_arbiter_bench;

    localparam int NUM_SRC   = 13;
    localparam int BUS_W     = 16;
    localparam int VEC_SHIFT = 1;
    localparam int ADDR_W    = $clog2(NUM_SRC) + VEC_SHIFT;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_event = '0;
    logic               reti = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_we = 1'b0;
    logic [1:0]         bus_addr = '0;
    logic [BUS_W-1:0]   bus_wdata = '0;
    logic [BUS_W-1:0]   bus_rdata;
    logic               vec_take;
    logic [ADDR_W-1:0]  vec_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_arbiter #(
        .NUM_SRC   (NUM_SRC),
        .BUS_W     (BUS_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_irq_vec_arbiter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_event_i (src_event),
        .reti_i      (reti),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .vec_take_o  (vec_take),
        .vec_addr_o  (vec_addr)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input int data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = 2'(addr);
        bus_wdata = BUS_W'(data);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input int addr, output int data);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = 2'(addr);
        #1;
        data     = int'(bus_rdata);
        bus_sel  = 1'b0;
    endtask

    task automatic pulse_event(input int mask);
        @(negedge clk);
        src_event = NUM_SRC'(mask);
        @(negedge clk);
        src_event = '0;
    endtask

    task automatic send_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    // Waits up to maxc falling edges for a take; reports how many were needed
    task automatic wait_take(input int maxc, output bit seen, output int addr, output int cyc);
        seen = 1'b0;
        addr = 0;
        cyc  = 0;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (vec_take && !seen) begin
                seen = 1'b1;
                addr = int'(vec_addr);
                cyc  = i;
                break;
            end
        end
    endtask

    task automatic test_reset();
        int rd;
        check_eq("R1 take after reset", int'(vec_take), 0);
        check_eq("R1 vector after reset", int'(vec_addr), 0);
        bus_read(0, rd); check_eq("R1 enable reg after reset", rd, 0);
        bus_read(1, rd); check_eq("R1 flag reg after reset", rd, 0);
        bus_read(2, rd); check_eq("R1 ctrl reg after reset", rd, 0);
        bus_read(3, rd); check_eq("R4 spare address reads 0", rd, 0);
    endtask

    task automatic test_latch_and_clear();
        bit seen; int a; int c; int rd;
        pulse_event(1 << 5);
        bus_read(1, rd); check_eq("R2 flag latched while disabled", rd, 32'h20);
        wait_take(5, seen, a, c); check_eq("R5 no take without enables", int'(seen), 0);
        bus_write(0, 1 << 5);
        wait_take(5, seen, a, c); check_eq("R5 no take with global closed", int'(seen), 0);
        bus_write(0, 16'hFFFF);
        bus_read(0, rd); check_eq("R4 enable readback, bit 0 and upper bits zero", rd, 32'h1FFE);
        bus_write(0, 0);
        pulse_event(1 << 8);
        bus_write(1, 1 << 8);
        bus_read(1, rd); check_eq("R3 write 1 clears, write 0 keeps", rd, 32'h20);
        bus_write(1, 1 << 5);
        bus_read(1, rd); check_eq("R3 flag cleared by write 1", rd, 0);
    endtask

    task automatic test_priority_order();
        bit seen; int a; int c; int rd;
        bus_write(0, 32'h1FFE);
        pulse_event((1 << 3) | (1 << 7) | (1 << 9));
        bus_write(2, 1);
        wait_take(4, seen, a, c);
        check_eq("R7 lowest index taken first", a, 3 << VEC_SHIFT);
        check_eq("R8 take seen", int'(seen), 1);
        @(negedge clk); check_eq("R8 take is a single-cycle pulse", int'(vec_take), 0);
        check_eq("R8 vector held after pulse", int'(vec_addr), 3 << VEC_SHIFT);
        bus_read(2, rd); check_eq("R8 global enable cleared on take", rd, 0);
        bus_read(1, rd); check_eq("R8 served flag cleared, others kept", rd, 32'h280);
        send_reti();
        wait_take(4, seen, a, c); check_eq("R10 next pending taken after return", a, 7 << VEC_SHIFT);
        send_reti();
        wait_take(4, seen, a, c); check_eq("R10 last pending taken after return", a, 9 << VEC_SHIFT);
        send_reti();
        wait_take(4, seen, a, c); check_eq("R10 no take when nothing pending", int'(seen), 0);
        bus_read(2, rd); check_eq("R10 return sets global enable", rd, 1);
        bus_write(2, 0);
    endtask

    task automatic test_reset_source();
        bit seen; int a; int c; int rd;
        bus_write(0, 0);
        pulse_event(1);
        wait_take(4, seen, a, c);
        check_eq("R6 reset source taken with all enables off", int'(seen), 1);
        check_eq("R6 reset source vector", a, 0);
        bus_read(1, rd); check_eq("R6 reset flag cleared by take", rd, 0);
    endtask

    task automatic test_nested();
        bit seen; int a; int c; int rd;
        bus_write(0, 32'h1FFE);
        bus_write(2, 1);
        pulse_event(1 << 6);
        wait_take(4, seen, a, c);
        check_eq("R9 take after one extra edge", c, 1);
        check_eq("R9 vector of source 6", a, 6 << VEC_SHIFT);
        pulse_event(1 << 2);
        wait_take(4, seen, a, c); check_eq("R10 no take during service", int'(seen), 0);
        bus_read(1, rd); check_eq("R10 flag kept during service", rd, 32'h4);
        bus_write(2, 1);
        wait_take(4, seen, a, c); check_eq("R11 nested take after global reopened", a, 2 << VEC_SHIFT);
        send_reti();
        bus_write(2, 0);
    endtask

    task automatic test_mask_with_gie();
        bit seen; int a; int c;
        bus_write(0, 0);
        bus_write(2, 1);
        pulse_event(1 << 4);
        wait_take(4, seen, a, c); check_eq("R5 masked source not taken", int'(seen), 0);
        bus_write(0, 1 << 4);
        wait_take(4, seen, a, c);
        check_eq("R5 taken once enabled", a, 4 << VEC_SHIFT);
        check_eq("R5 taken on the edge after the enable write", c, 1);
    endtask

    task automatic test_set_wins_bus_clear();
        int rd;
        @(negedge clk);
        src_event = NUM_SRC'(1 << 10);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = 2'd1;
        bus_wdata = BUS_W'(1 << 10);
        @(negedge clk);
        src_event = '0;
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        bus_read(1, rd); check_eq("R2 event wins over same-cycle bus clear", rd, 32'h400);
        bus_write(1, 1 << 10);
    endtask

    task automatic test_set_wins_take();
        bit seen; int a; int c; int rd;
        bus_write(0, 1 << 11);
        bus_write(2, 1);
        @(negedge clk);
        src_event = NUM_SRC'(1 << 11);
        @(negedge clk);
        @(negedge clk);
        src_event = '0;
        check_eq("R8 take while event held", int'(vec_take), 1);
        check_eq("R8 vector of source 11", int'(vec_addr), 11 << VEC_SHIFT);
        bus_read(1, rd); check_eq("R2 event wins over take clear", rd, 32'h800);
        send_reti();
        wait_take(4, seen, a, c); check_eq("R10 re-raised flag taken after return", a, 11 << VEC_SHIFT);
        bus_read(1, rd); check_eq("R8 flag cleared after second take", rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_latch_and_clear();
        test_priority_order();
        test_reset_source();
        test_nested();
        test_mask_with_gie();
        test_set_wins_bus_clear();
        test_set_wins_take();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule